// File: doc/BRIEF.md
# Compare-Match Timer

This block is an up-counting timer with two compare channels. A small register window, reached with single-cycle writes and combinational reads, sets the waveform mode, the action each channel takes on a compare hit, the clock division, the counter value and the two compare values. Each channel keeps a sticky hit flag and a waveform bit. The waveform bit can replace the general-purpose value on that channel's pad.

Three counting modes are available. Free-running mode wraps at the all-ones value. Clear-on-compare mode uses compare value A as its ceiling. Fast PWM mode runs to the all-ones value and shapes its output at both the compare point and the wrap point. The counter only moves on ticks from a divider. The divider restarts whenever its setting is written.

Register offsets: 0 control, 1 clock select, 2 counter, 3 compare A, 4 compare B, 5 flags.

Top module: `tmr_cmpout`

## Requirements
- R1: After reset every register reads 0, both flags are 0, both waveform bits are 0, and each pad carries its general-purpose value.
- R2: Control (offset 0) holds the channel A action in bits 7:6, the channel B action in bits 5:4 and the mode in bits 1:0. Bits 3:2 always read 0. Clock select (offset 1) is 3 bits wide.
- R3: Clock select codes: 1 = every clock, 2 = every 8, 3 = every 64, 4 = every 256, 5 = every 1024, and 0, 6 or 7 = stopped. A write to clock select restarts the divider, so the first increment lands on the N-th rising edge after the write edge.
- R4: Mode 00 (and 01) is free-running. On a tick the counter goes from all-ones to 0.
- R5: Mode 10 is clear-on-compare. On a tick with the counter equal to compare A, the counter goes to 0.
- R6: A channel's flag (flag bit 0 = A, bit 1 = B) is set by a tick on which the counter equals that channel's active compare value. In mode 10 this is the ceiling-to-zero step.
- R7: Writing 1 to a flag bit clears it and writing 0 has no effect. A hit in the same cycle keeps the flag set.
- R8: Outside fast PWM, a hit with action 01 toggles the waveform bit, 10 clears it and 11 sets it. Action 00 leaves it alone.
- R9: In fast PWM (mode 11), action 10 clears the bit on a hit and sets it on the all-ones tick. Action 11 does the reverse. When both fall on one tick, the all-ones action wins.
- R10: Outside fast PWM a compare write takes effect at once. In fast PWM it goes to a buffer that reads back immediately and becomes active on the all-ones tick.
- R11: A pad carries the waveform bit when its action is nonzero (fast PWM: only 10 or 11). Otherwise it carries its general-purpose value. The pad enable always equals the channel's direction input.
- R12: A counter write loads the value and overrides any tick in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr |
| gp_val | input | 2 | General-purpose pad values (bit 0 = A) |
| gp_dir | input | 2 | Pad direction bits |
| pad_out | output | 2 | Pad values after override |
| pad_oe | output | 2 | Pad drive enables |
| match_flag | output | 2 | Sticky compare hit flags |

## Verification
The properties assume that bus_addr and bus_wdata are meaningful only while bus_wr is high, and that at most one register is written per cycle. They also assume the clear-on-compare ceiling is reached by counting, without the counter being written past it. The stimulus sets up modes, compare values and the counter while the divider is stopped. It then starts the divider with one write, so each hit and wrap falls on a known edge. Writes while the counter is running occur only where a collision is the thing being tested, such as a flag clear on a hit edge or a compare write in fast PWM.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      WG_FREE     = 2'b00,
      WG_FREE_ALT = 2'b01,
      WG_CLR_CMP  = 2'b10,
      WG_FPWM     = 2'b11
   } wave_mode_e;

   typedef enum logic [1:0] {
      ACT_OFF    = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_CLEAR  = 2'b10,
      ACT_SET    = 2'b11
   } cmp_act_e;

   localparam logic [2:0] RA_CTRL  = 3'd0;
   localparam logic [2:0] RA_CSEL  = 3'd1;
   localparam logic [2:0] RA_COUNT = 3'd2;
   localparam logic [2:0] RA_CMPA  = 3'd3;
   localparam logic [2:0] RA_CMPB  = 3'd4;
   localparam logic [2:0] RA_FLAG  = 3'd5;

   localparam int unsigned NUM_CH = 2;

   // log2 of the division ratio for a clock select code
   function automatic int unsigned div_shift(input logic [2:0] sel);
      case (sel)
         3'd2:    return 3;
         3'd3:    return 6;
         3'd4:    return 8;
         3'd5:    return 10;
         default: return 0;
      endcase
   endfunction

   function automatic logic sel_runs(input logic [2:0] sel);
      return (sel >= 3'd1) && (sel <= 3'd5);
   endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
   import tmr_pkg::*;
#(
   parameter int unsigned PSC_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   input  logic       restart,
   output logic       tick
);

   logic [PSC_W-1:0] psc_q;
   logic [PSC_W-1:0] mask;
   logic             run;

   always_comb begin
      mask = PSC_W'((32'd1 << div_shift(sel)) - 32'd1);
      run  = sel_runs(sel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                psc_q <= '0;
      else if (restart || !run)  psc_q <= '0;
      else                       psc_q <= psc_q + 1'b1;
   end

   assign tick = run && ((psc_q & mask) == mask);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  wave_mode_e       wmode,
   input  logic [CNT_W-1:0] ceil_cmp,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             at_top
);

   logic [CNT_W-1:0] top;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      case (wmode)
         WG_CLR_CMP: top = ceil_cmp;
         default:    top = '1;
      endcase
   end

   assign at_top = (cnt_q == top);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (load)  cnt_q <= load_val;
      else if (tick)  cnt_q <= at_top ? '0 : cnt_q + 1'b1;
   end

   assign count = cnt_q;

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             at_top,
   input  logic [CNT_W-1:0] count,
   input  wave_mode_e       wmode,
   input  cmp_act_e         act,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cmp_buf,
   output logic [CNT_W-1:0] cmp_act,
   output logic             flag,
   output logic             wave,
   output logic             ovr
);

   logic             is_pwm;
   logic             hit;
   logic             wrap;
   logic [CNT_W-1:0] buf_q;
   logic [CNT_W-1:0] act_q;
   logic             flag_q;
   logic             wave_q;
   logic             wave_d;

   assign is_pwm = (wmode == WG_FPWM);
   assign hit    = tick && (count == act_q);
   assign wrap   = tick && at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         act_q <= '0;
      end else begin
         if (cmp_wr) buf_q <= cmp_wdata;
         if (cmp_wr && !is_pwm)   act_q <= cmp_wdata;
         else if (is_pwm && wrap) act_q <= buf_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (hit)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   always_comb begin
      wave_d = wave_q;
      if (is_pwm) begin
         if (hit) begin
            case (act)
               ACT_CLEAR: wave_d = 1'b0;
               ACT_SET:   wave_d = 1'b1;
               default:   wave_d = wave_q;
            endcase
         end
         if (wrap) begin
            case (act)
               ACT_CLEAR: wave_d = 1'b1;
               ACT_SET:   wave_d = 1'b0;
               default:   wave_d = wave_d;
            endcase
         end
      end else if (hit) begin
         case (act)
            ACT_TOGGLE: wave_d = ~wave_q;
            ACT_CLEAR:  wave_d = 1'b0;
            ACT_SET:    wave_d = 1'b1;
            default:    wave_d = wave_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wave_q <= 1'b0;
      else        wave_q <= wave_d;
   end

   assign ovr     = is_pwm ? act[1] : (act != ACT_OFF);
   assign cmp_buf = buf_q;
   assign cmp_act = act_q;
   assign flag    = flag_q;
   assign wave    = wave_q;

endmodule

// File: rtl/tmr_cmpout.sv
module tmr_cmpout
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned PSC_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic [1:0]       gp_val,
   input  logic [1:0]       gp_dir,
   output logic [1:0]       pad_out,
   output logic [1:0]       pad_oe,
   output logic [1:0]       match_flag
);

   if (CNT_W < 8 || CNT_W > 16) begin : g_cnt_w_chk
      $error("tmr_cmpout: CNT_W must lie in 8..16");
   end
   if (PSC_W < 10 || PSC_W > 16) begin : g_psc_w_chk
      $error("tmr_cmpout: PSC_W must lie in 10..16");
   end

   logic [3:0]       act_fields_q;
   logic [1:0]       wmode_q;
   logic [2:0]       csel_q;
   wave_mode_e       wmode;
   logic             cnt_tick;
   logic             cnt_top;
   logic [CNT_W-1:0] cnt_val;
   logic             wr_ctrl, wr_csel, wr_count, wr_flag;

   logic [NUM_CH-1:0]            ch_wr;
   logic [NUM_CH-1:0]            ch_clr;
   logic [NUM_CH-1:0]            flags;
   logic [NUM_CH-1:0]            wave;
   logic [NUM_CH-1:0]            ovr;
   logic [NUM_CH-1:0][1:0]       act_code;
   logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf;
   logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;

   assign wr_ctrl  = bus_wr && (bus_addr == RA_CTRL);
   assign wr_csel  = bus_wr && (bus_addr == RA_CSEL);
   assign wr_count = bus_wr && (bus_addr == RA_COUNT);
   assign wr_flag  = bus_wr && (bus_addr == RA_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_fields_q <= '0;
         wmode_q      <= '0;
         csel_q       <= '0;
      end else begin
         if (wr_ctrl) begin
            act_fields_q <= bus_wdata[7:4];
            wmode_q      <= bus_wdata[1:0];
         end
         if (wr_csel) csel_q <= bus_wdata[2:0];
      end
   end

   assign wmode       = wave_mode_e'(wmode_q);
   assign act_code[0] = act_fields_q[3:2];
   assign act_code[1] = act_fields_q[1:0];

   tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (csel_q),
      .restart (wr_csel),
      .tick    (cnt_tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (cnt_tick),
      .wmode    (wmode),
      .ceil_cmp (cmp_act[0]),
      .load     (wr_count),
      .load_val (bus_wdata),
      .count    (cnt_val),
      .at_top   (cnt_top)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ch_wr[c]  = bus_wr && (bus_addr == RA_CMPA + 3'(c));
      assign ch_clr[c] = wr_flag && bus_wdata[c];

      tmr_cmp_chan #(.CNT_W(CNT_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (cnt_tick),
         .at_top    (cnt_top),
         .count     (cnt_val),
         .wmode     (wmode),
         .act       (cmp_act_e'(act_code[c])),
         .cmp_wr    (ch_wr[c]),
         .cmp_wdata (bus_wdata),
         .flag_clr  (ch_clr[c]),
         .cmp_buf   (cmp_buf[c]),
         .cmp_act   (cmp_act[c]),
         .flag      (flags[c]),
         .wave      (wave[c]),
         .ovr       (ovr[c])
      );

      assign pad_out[c] = ovr[c] ? wave[c] : gp_val[c];
      assign pad_oe[c]  = gp_dir[c];
   end

   always_comb begin
      case (bus_addr)
         RA_CTRL:  bus_rdata = CNT_W'({act_fields_q, 2'b00, wmode_q});
         RA_CSEL:  bus_rdata = CNT_W'(csel_q);
         RA_COUNT: bus_rdata = cnt_val;
         RA_CMPA:  bus_rdata = cmp_buf[0];
         RA_CMPB:  bus_rdata = cmp_buf[1];
         RA_FLAG:  bus_rdata = CNT_W'(flags);
         default:  bus_rdata = '0;
      endcase
   end

   assign match_flag = flags;

endmodule

// File: rtl/tmr_cmpout_chk.sv
module tmr_cmpout_chk
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [2:0]       bus_addr,
   input logic [CNT_W-1:0] bus_wdata,
   input logic             cnt_tick,
   input logic [CNT_W-1:0] cnt_val,
   input logic [CNT_W-1:0] cmp_a_act,
   input logic [1:0]       wmode,
   input logic [1:0]       code_a,
   input logic [1:0]       flags,
   input logic [1:0]       gp_val,
   input logic [1:0]       pad_out
);

   logic hit_a;
   assign hit_a = cnt_tick && (cnt_val == cmp_a_act);

   p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_tick && !(bus_wr && bus_addr == RA_COUNT)) |=> $stable(cnt_val));

   p_ctc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wmode == WG_CLR_CMP && hit_a && !(bus_wr && bus_addr == RA_COUNT))
      |=> (cnt_val == '0));

   p_flag_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(cnt_tick));

   p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RA_FLAG && bus_wdata[0] && !hit_a) |=> !flags[0]);

   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_a |=> flags[0]);

   p_pwm_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wmode == WG_FPWM && cnt_tick && cnt_val == '1 && code_a == ACT_CLEAR
       && !(bus_wr && bus_addr == RA_CTRL)) |=> pad_out[0]);

   p_pad_gp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (code_a == ACT_OFF) |-> (pad_out[0] == gp_val[0]));

endmodule

bind tmr_cmpout tmr_cmpout_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .cnt_tick  (cnt_tick),
   .cnt_val   (cnt_val),
   .cmp_a_act (cmp_act[0]),
   .wmode     (wmode_q),
   .code_a    (act_code[0]),
   .flags     (flags),
   .gp_val    (gp_val),
   .pad_out   (pad_out)
);

// File: tb/tmr_cmpout_tb.sv
module tmr_cmpout_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] gp_val = 2'b10;
   logic [1:0] gp_dir = 2'b01;
   logic [1:0] pad_out;
   logic [1:0] pad_oe;
   logic [1:0] match_flag;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   tmr_cmpout dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .gp_val     (gp_val),
      .gp_dir     (gp_dir),
      .pad_out    (pad_out),
      .pad_oe     (pad_oe),
      .match_flag (match_flag)
   );

   localparam logic [2:0] CTRL = 3'd0, CSEL = 3'd1, CNT = 3'd2,
                          CMPA = 3'd3, CMPB = 3'd4, FLAG = 3'd5;

   // {offset, write value, expected read-back}
   localparam int NV = 8;
   localparam logic [18:0] VEC [NV] = '{
      {CSEL, 8'hFF, 8'h07}, {CSEL, 8'h00, 8'h00},
      {CNT,  8'h3C, 8'h3C}, {CMPA, 8'hA5, 8'hA5},
      {CMPB, 8'h5A, 8'h5A}, {CTRL, 8'hFF, 8'hF3},
      {CTRL, 8'h0C, 8'h00}, {FLAG, 8'h00, 8'h00}
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called just after a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rdchk(input string req, input logic [2:0] a, input int exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, int'(v), exp);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rdchk("R1 ctrl", CTRL, 0);
      rdchk("R1 count", CNT, 0);
      rdchk("R1 flags", FLAG, 0);
      chk("R1 pad_out", int'(pad_out), 2);
      chk("R1 pad_oe", int'(pad_oe), 1);
      chk("R1 match_flag", int'(match_flag), 0);

      // register map walk: R2 R10 R12
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][18:16], VEC[i][15:8]);
         rdchk("R2 R10 R12 readback", VEC[i][18:16], int'(VEC[i][7:0]));
      end

      // R3 divide by 8
      wr(CNT, 8'h00);
      wr(CSEL, 8'd2);
      repeat (7) @(negedge clk);
      rdchk("R3 div8 before", CNT, 0);
      @(negedge clk);
      rdchk("R3 div8 first step", CNT, 1);
      // R3 divide by 64
      wr(CSEL, 8'd0);
      wr(CNT, 8'h00);
      wr(CSEL, 8'd3);
      repeat (63) @(negedge clk);
      rdchk("R3 div64 before", CNT, 0);
      @(negedge clk);
      rdchk("R3 div64 first step", CNT, 1);
      // R3 stopped codes
      wr(CSEL, 8'd6);
      repeat (20) @(negedge clk);
      rdchk("R3 code 6 stopped", CNT, 1);
      wr(CSEL, 8'd0);
      repeat (20) @(negedge clk);
      rdchk("R3 code 0 stopped", CNT, 1);

      // R4 free-running wrap, R6 flag B, R8 set action, R10 immediate
      gp_val = 2'b00;
      wr(FLAG, 8'h03);
      wr(CTRL, 8'h30);
      wr(CMPB, 8'hFF);
      wr(CNT, 8'hFE);
      wr(CSEL, 8'd1);
      @(negedge clk);
      rdchk("R4 count at ff", CNT, 8'hFF);
      chk("R6 flag B not yet", int'(match_flag[1]), 0);
      @(negedge clk);
      rdchk("R4 wrap to 0", CNT, 0);
      chk("R6 flag B set", int'(match_flag[1]), 1);
      chk("R8 set on hit", int'(pad_out[1]), 1);
      wr(CSEL, 8'd0);

      // R5 clear-on-compare, R6, R7, R8 toggle
      wr(FLAG, 8'h03);
      wr(CTRL, 8'h42);
      wr(CMPA, 8'h03);
      wr(CNT, 8'h00);
      wr(CSEL, 8'd1);
      repeat (3) @(negedge clk);
      rdchk("R5 at ceiling", CNT, 3);
      chk("R6 flag A not yet", int'(match_flag[0]), 0);
      @(negedge clk);
      rdchk("R5 back to 0", CNT, 0);
      chk("R6 flag A on wrap", int'(match_flag[0]), 1);
      chk("R8 toggle high", int'(pad_out[0]), 1);
      wr(FLAG, 8'h01);
      chk("R7 write-1 clear", int'(match_flag[0]), 0);
      repeat (2) @(negedge clk);
      wr(FLAG, 8'h01);
      chk("R7 set wins", int'(match_flag[0]), 1);
      chk("R8 toggle low", int'(pad_out[0]), 0);
      wr(FLAG, 8'h00);
      chk("R7 write-0 ignored", int'(match_flag[0]), 1);
      wr(CSEL, 8'd0);
      gp_dir = 2'b10;
      #1;
      chk("R11 pad_oe follows dir", int'(pad_oe), 2);

      // R9 fast PWM, R10 buffered compare
      wr(CTRL, 8'h00);
      wr(CMPA, 8'h02);
      wr(CNT, 8'hFE);
      wr(CTRL, 8'h83);
      wr(CSEL, 8'd1);
      repeat (2) @(negedge clk);
      chk("R9 set at wrap", int'(pad_out[0]), 1);
      repeat (2) @(negedge clk);
      chk("R9 high through cmp", int'(pad_out[0]), 1);
      @(negedge clk);
      chk("R9 cleared after cmp", int'(pad_out[0]), 0);
      wr(CMPA, 8'h05);
      rdchk("R10 buffer readback", CMPA, 5);
      wr(CNT, 8'hFE);
      repeat (5) @(negedge clk);
      chk("R10 old value retired", int'(pad_out[0]), 1);
      repeat (2) @(negedge clk);
      chk("R10 new value pending", int'(pad_out[0]), 1);
      @(negedge clk);
      chk("R10 new value hit", int'(pad_out[0]), 0);
      wr(CSEL, 8'd0);

      // R11 override rules
      gp_val = 2'b01;
      wr(CTRL, 8'h43);
      chk("R11 pwm code 01 no override", int'(pad_out[0]), 1);
      wr(CTRL, 8'h40);
      chk("R11 code 01 overrides", int'(pad_out[0]), 0);
      wr(CTRL, 8'h00);
      chk("R11 code 00 gp value", int'(pad_out[0]), 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule